// File: doc/BRIEF.md
# VLAN Table Command Engine

This block keeps a small VLAN membership table for an Ethernet switch and exposes it to a host only through a handful of 16-bit registers on a plain synchronous read/write port. The host fills a key register (VLAN number plus a valid flag) and the per-port membership data registers. It then writes the command register with its busy bit set. The engine walks the whole table once, acts on the result and clears busy.

Three commands exist. Load/purge inserts, overwrites or removes the entry for one VLAN number. Get-next finds the lowest stored VLAN number strictly above the key and writes it back into the key register, so repeating the command walks the table in ascending order. Flush-all empties the table. Each entry carries a 13-bit VLAN number, a valid flag, an 8-bit filtering database number and a 2-bit membership code for each port.

Every command takes the same number of cycles whatever the table holds, so the host's polling time is fixed.

Top module: `vtab_engine`

## Requirements
- R1: After a synchronous reset every register reads zero: busy clear, table empty, table-full flag clear.
- R2: Register addresses are 0 = command, 1 = key, 2..4 = data words 0..2. A write to the command register with bit 15 set starts the command whose code is in bits 14:12: 1 = flush-all, 3 = load/purge, 4 = get-next. Bit 15 then reads 1 for exactly DEPTH+1 cycles and clears by itself.
- R3: While busy reads 1, host writes to any register have no effect, and a second start is not taken.
- R4: The key register holds VLAN bits 11:0 in bits 11:0, VLAN bit 12 in bit 12 and the valid flag in bit 15. Bits 14:13 read zero.
- R5: Load/purge with the key valid flag set stores the entry for the key's VLAN number, or replaces an existing entry with that number.
- R6: Load/purge with the key valid flag clear removes the entry with the key's VLAN number, if one exists.
- R7: Get-next finds the lowest stored VLAN number strictly greater than the key. It writes that number with valid set into the key register, and the entry's database number and membership codes into the command and data registers. Repeating it without rewriting the key visits the entries in ascending order.
- R8: When no stored number is above the key, get-next clears only the key's valid flag. The key's number bits and the data registers keep their values.
- R9: The membership code of port k is bits 4*(k mod 4)+1 : 4*(k mod 4) of data word k/4. A load takes only those bits. After a successful get-next, all other data bits read zero.
- R10: The database number is split across the command register. The low nibble is in bits 3:0 and the high nibble in bits 11:8, both when a load supplies it and when get-next returns it.
- R11: Flush-all invalidates every entry and clears the table-full flag.
- R12: A load of a new VLAN number into a full table leaves the table unchanged and sets a sticky table-full flag at command bit 4. Replacing an existing entry still works when the table is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register, combinational |

## Verification
The assertions assume that the host never changes the table contents except by command. They also assume that the registers stay frozen for the length of a scan, which the block itself enforces by ignoring writes while busy. The random stimulus respects the same protocol. It issues each command only after busy has been seen clear, and it draws VLAN numbers from a fixed pool of 24 non-zero values. That pool exceeds the table depth, so the full case comes up. A walk that starts from key zero reaches every stored entry. The directed cases add deliberate writes during busy to exercise the ignore path.

// File: rtl/vtab_pkg.sv
package vtab_pkg;

    localparam int ADDR_W  = 3;
    localparam int VID_W   = 13;
    localparam int FID_W   = 8;
    localparam int MAXP    = 12;
    localparam int MEM_W   = 2 * MAXP;

    localparam logic [ADDR_W-1:0] A_CMD = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY = 3'd1;
    localparam logic [ADDR_W-1:0] A_D0  = 3'd2;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_FLUSH = 3'd1,
        OP_LOAD  = 3'd3,
        OP_NEXT  = 3'd4
    } op_e;

    typedef struct packed {
        logic             valid;
        logic [VID_W-1:0] vid;
        logic [FID_W-1:0] fid;
        logic [MEM_W-1:0] mem;
    } entry_t;

    // Packs the four membership codes that live in data word w.
    function automatic logic [15:0] pack_word(input logic [MEM_W-1:0] m, input int w);
        logic [15:0] r;
        r = '0;
        for (int p = 0; p < 4; p++) begin
            r[4*p +: 2] = m[2*(4*w+p) +: 2];
        end
        return r;
    endfunction

endpackage

// File: rtl/vtab_store.sv
module vtab_store
    import vtab_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  entry_t           wentry,
    input  logic [IDX_W-1:0] ridx,
    output entry_t           rentry
);

    entry_t slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (we) begin
            slot_q[widx] <= wentry;
        end
    end

    assign rentry = slot_q[ridx];

endmodule

// File: rtl/vtab_seq.sv
module vtab_seq
    import vtab_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [VID_W-1:0] key_vid,
    input  logic             key_valid,
    input  logic [FID_W-1:0] key_fid,
    input  logic [MEM_W-1:0] key_mem,
    output logic [IDX_W-1:0] rd_idx,
    input  entry_t           rd_ent,
    output logic             st_we,
    output logic [IDX_W-1:0] st_widx,
    output entry_t           st_wentry,
    output logic             done,
    output logic             upd_en,
    output entry_t           res,
    output logic             full
);

    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_COMMIT} state_e;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    state_e           state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cyc_q;
    logic             hit_q, free_q, best_q, full_q;
    logic [IDX_W-1:0] hit_idx_q, free_idx_q;
    entry_t           best_ent_q;

    logic is_hit, is_free, is_better;

    always_comb begin
        is_hit    = rd_ent.valid && (rd_ent.vid == key_vid);
        is_free   = !rd_ent.valid;
        is_better = rd_ent.valid && (rd_ent.vid > key_vid) &&
                    (!best_q || (rd_ent.vid < best_ent_q.vid));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            idx_q      <= '0;
            cyc_q      <= '0;
            hit_q      <= 1'b0;
            free_q     <= 1'b0;
            best_q     <= 1'b0;
            full_q     <= 1'b0;
            hit_idx_q  <= '0;
            free_idx_q <= '0;
            best_ent_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_q <= S_SCAN;
                        idx_q   <= '0;
                        cyc_q   <= '0;
                        hit_q   <= 1'b0;
                        free_q  <= 1'b0;
                        best_q  <= 1'b0;
                    end
                end
                S_SCAN: begin
                    cyc_q <= cyc_q + 1'b1;
                    if (is_hit && !hit_q) begin
                        hit_q     <= 1'b1;
                        hit_idx_q <= idx_q;
                    end
                    if (is_free && !free_q) begin
                        free_q     <= 1'b1;
                        free_idx_q <= idx_q;
                    end
                    if (is_better) begin
                        best_q     <= 1'b1;
                        best_ent_q <= rd_ent;
                    end
                    if (idx_q == LAST) begin
                        state_q <= S_COMMIT;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                    if (op == OP_FLUSH) begin
                        full_q <= 1'b0;
                    end else if (op == OP_LOAD && key_valid && !hit_q && !free_q) begin
                        full_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        st_we     = 1'b0;
        st_widx   = '0;
        st_wentry = '0;
        if (state_q == S_SCAN && op == OP_FLUSH) begin
            st_we   = 1'b1;
            st_widx = idx_q;
        end else if (state_q == S_COMMIT && op == OP_LOAD) begin
            if (key_valid) begin
                st_wentry = '{valid: 1'b1, vid: key_vid, fid: key_fid, mem: key_mem};
                if (hit_q) begin
                    st_we   = 1'b1;
                    st_widx = hit_idx_q;
                end else if (free_q) begin
                    st_we   = 1'b1;
                    st_widx = free_idx_q;
                end
            end else if (hit_q) begin
                st_we   = 1'b1;
                st_widx = hit_idx_q;
            end
        end
    end

    assign rd_idx = idx_q;
    assign done   = (state_q == S_COMMIT);
    assign upd_en = done && (op == OP_NEXT);
    assign full   = full_q;

    always_comb begin
        res       = best_ent_q;
        res.valid = best_q;
    end

    // R2
    scan_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_COMMIT) |-> (cyc_q == CNT_W'(DEPTH)));

    // R7
    next_above_key_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && best_q) |-> (best_ent_q.vid > key_vid));

    // R11
    flush_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
        (done && op == OP_FLUSH) |=> !full_q);

    // R12
    full_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(full_q) |-> $past(done && op == OP_FLUSH));

endmodule

// File: rtl/vtab_regs.sv
module vtab_regs
    import vtab_pkg::*;
#(
    parameter  int NPORTS = 12,
    localparam int NDATA  = (NPORTS + 3) / 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              start,
    output logic [2:0]        op,
    output logic [VID_W-1:0]  key_vid,
    output logic              key_valid,
    output logic [FID_W-1:0]  key_fid,
    output logic [MEM_W-1:0]  key_mem,
    input  logic              done,
    input  logic              upd_en,
    input  entry_t            res,
    input  logic              full
);

    logic             busy_q, vval_q;
    logic [2:0]       opc_q;
    logic [FID_W-1:0] fid_q;
    logic [VID_W-1:0] vid_q;
    logic [15:0]      data_q [NDATA];

    logic host_wr;
    assign host_wr = wr_en && !busy_q;
    assign start   = host_wr && (addr == A_CMD) && wdata[15];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            vval_q <= 1'b0;
            opc_q  <= '0;
            fid_q  <= '0;
            vid_q  <= '0;
            for (int w = 0; w < NDATA; w++) data_q[w] <= '0;
        end else if (host_wr) begin
            if (addr == A_CMD) begin
                opc_q  <= wdata[14:12];
                fid_q  <= {wdata[11:8], wdata[3:0]};
                busy_q <= wdata[15];
            end
            if (addr == A_KEY) begin
                vval_q <= wdata[15];
                vid_q  <= wdata[12:0];
            end
            for (int w = 0; w < NDATA; w++) begin
                if (addr == ADDR_W'(32'(A_D0) + w)) data_q[w] <= wdata;
            end
        end else if (done) begin
            busy_q <= 1'b0;
            if (upd_en) begin
                vval_q <= res.valid;
                if (res.valid) begin
                    vid_q <= res.vid;
                    fid_q <= res.fid;
                    for (int w = 0; w < NDATA; w++) data_q[w] <= pack_word(res.mem, w);
                end
            end
        end
    end

    always_comb begin
        key_mem = '0;
        for (int p = 0; p < NPORTS; p++) begin
            key_mem[2*p +: 2] = data_q[p/4][4*(p%4) +: 2];
        end
    end

    assign op        = opc_q;
    assign key_vid   = vid_q;
    assign key_valid = vval_q;
    assign key_fid   = fid_q;

    always_comb begin
        rdata = '0;
        if (addr == A_CMD) begin
            rdata = {busy_q, opc_q, fid_q[7:4], 3'b000, full, fid_q[3:0]};
        end else if (addr == A_KEY) begin
            rdata = {vval_q, 2'b00, vid_q};
        end
        for (int w = 0; w < NDATA; w++) begin
            if (addr == ADDR_W'(32'(A_D0) + w)) rdata = data_q[w];
        end
    end

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_q);

    // R3
    busy_key_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> (vid_q == $past(vid_q)) && (vval_q == $past(vval_q)));

    // R3
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !start);

endmodule

// File: rtl/vtab_engine.sv
module vtab_engine
    import vtab_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int NPORTS = 12,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);

    logic             start, key_valid, done, upd_en, full, st_we;
    logic [2:0]       op;
    logic [VID_W-1:0] key_vid;
    logic [FID_W-1:0] key_fid;
    logic [MEM_W-1:0] key_mem;
    logic [IDX_W-1:0] rd_idx, st_widx;
    entry_t           rd_ent, st_wentry, res;

    vtab_regs #(.NPORTS(NPORTS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .start(start), .op(op), .key_vid(key_vid),
        .key_valid(key_valid), .key_fid(key_fid), .key_mem(key_mem),
        .done(done), .upd_en(upd_en), .res(res), .full(full)
    );

    vtab_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .start(start), .op(op), .key_vid(key_vid),
        .key_valid(key_valid), .key_fid(key_fid), .key_mem(key_mem),
        .rd_idx(rd_idx), .rd_ent(rd_ent), .st_we(st_we), .st_widx(st_widx),
        .st_wentry(st_wentry), .done(done), .upd_en(upd_en), .res(res),
        .full(full)
    );

    vtab_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .we(st_we), .widx(st_widx), .wentry(st_wentry),
        .ridx(rd_idx), .rentry(rd_ent)
    );

endmodule

// File: tb/vtab_engine_tb.sv
module vtab_engine_tb;

    localparam int DEPTH = 16;
    localparam int NP    = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    always #5 clk = ~clk;

    vtab_engine #(.DEPTH(DEPTH), .NPORTS(NP)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int total = 0;
    int bad   = 0;

    // reference model
    logic        m_valid [DEPTH];
    logic [12:0] m_vid   [DEPTH];
    logic [7:0]  m_fid   [DEPTH];
    logic [23:0] m_mem   [DEPTH];
    logic        m_full;
    logic [15:0] e_key;
    logic [7:0]  e_fid;
    logic [15:0] e_data [3];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] unpack(input logic [15:0] d0, input logic [15:0] d1,
                                           input logic [15:0] d2);
        logic [23:0] m;
        logic [15:0] w;
        for (int p = 0; p < NP; p++) begin
            w = (p < 4) ? d0 : ((p < 8) ? d1 : d2);
            m[2*p +: 2] = w[4*(p%4) +: 2];
        end
        return m;
    endfunction

    function automatic logic [15:0] packw(input logic [23:0] m, input int w);
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++) r[4*p +: 2] = m[2*(4*w+p) +: 2];
        return r;
    endfunction

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] v;
        n = 0;
        rreg(3'd0, v);
        while (v[15] && n < 1000) begin
            n++;
            @(negedge clk);
            rreg(3'd0, v);
        end
    endtask

    task automatic cmd(input logic [2:0] opc, input logic [7:0] fid, output int n);
        wreg(3'd0, {1'b1, opc, fid[7:4], 4'b0000, fid[3:0]});
        e_fid = fid;
        wait_idle(n);
    endtask

    task automatic model_load(input logic [12:0] vid, input logic vld, input logic [7:0] fid,
                              input logic [23:0] mem);
        int hit = -1;
        int fr  = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_valid[i] && m_vid[i] == vid && hit < 0) hit = i;
            if (!m_valid[i] && fr < 0) fr = i;
        end
        if (vld) begin
            if (hit >= 0) begin
                m_fid[hit] = fid; m_mem[hit] = mem;
            end else if (fr >= 0) begin
                m_valid[fr] = 1'b1; m_vid[fr] = vid; m_fid[fr] = fid; m_mem[fr] = mem;
            end else begin
                m_full = 1'b1;
            end
        end else if (hit >= 0) begin
            m_valid[hit] = 1'b0;
        end
    endtask

    task automatic do_load(input logic [12:0] vid, input logic vld, input logic [7:0] fid,
                           input logic [15:0] d0, input logic [15:0] d1, input logic [15:0] d2);
        int n;
        e_key = {vld, 2'b00, vid};
        wreg(3'd1, e_key);
        wreg(3'd2, d0); wreg(3'd3, d1); wreg(3'd4, d2);
        e_data[0] = d0; e_data[1] = d1; e_data[2] = d2;
        cmd(3'd3, fid, n);
        model_load(vid, vld, fid, unpack(d0, d1, d2));
    endtask

    task automatic set_key(input logic [15:0] k);
        wreg(3'd1, k);
        e_key = {k[15], 2'b00, k[12:0]};
    endtask

    // get-next with full readback check; returns found flag
    task automatic next_chk(input string req, output logic found);
        int n;
        int best = -1;
        logic [15:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_valid[i] && m_vid[i] > e_key[12:0] &&
                (best < 0 || m_vid[i] < m_vid[best])) best = i;
        end
        cmd(3'd4, 8'h00, n);
        found = (best >= 0);
        if (found) begin
            e_key = {1'b1, 2'b00, m_vid[best]};
            e_fid = m_fid[best];
            for (int w = 0; w < 3; w++) e_data[w] = packw(m_mem[best], w);
        end else begin
            e_key[15] = 1'b0;
        end
        rreg(3'd1, v); chk({req, " key"}, v, e_key);
        rreg(3'd0, v); chk({req, " R10 cmd"}, v, {1'b0, 3'd4, e_fid[7:4], 3'b000, m_full, e_fid[3:0]});
        for (int w = 0; w < 3; w++) begin
            rreg(3'(2 + w), v); chk({req, " R9 data"}, v, e_data[w]);
        end
    endtask

    task automatic walk(input string req);
        logic f;
        set_key(16'h0000);
        f = 1'b1;
        for (int k = 0; k < DEPTH + 2 && f; k++) next_chk(req, f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic f;
        int n;
        void'($urandom(32'd9157));
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 0; m_vid[i] = 0; m_fid[i] = 0; m_mem[i] = 0;
        end
        m_full = 0; e_key = 0; e_fid = 0;
        for (int w = 0; w < 3; w++) e_data[w] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rreg(3'(a), v); chk("R1 reset", v, 16'h0000);
        end

        // R4 key register layout
        wreg(3'd1, 16'h9ABC); rreg(3'd1, v); chk("R4 key", v, 16'h9ABC);
        wreg(3'd1, 16'hFFFF); rreg(3'd1, v); chk("R4 key mask", v, 16'h9FFF);

        // R2 busy length, R5 load, R10 fid split
        e_key = {1'b1, 2'b00, 13'd300};
        wreg(3'd1, e_key);
        wreg(3'd2, 16'hFFFF); wreg(3'd3, 16'h1221); wreg(3'd4, 16'h0003);
        e_data[0] = 16'hFFFF; e_data[1] = 16'h1221; e_data[2] = 16'h0003;
        cmd(3'd3, 8'hA5, n);
        chk("R2 busy cycles", n, DEPTH + 1);
        model_load(13'd300, 1'b1, 8'hA5, unpack(16'hFFFF, 16'h1221, 16'h0003));
        rreg(3'd0, v); chk("R10 load fields", v, 16'h3A05);
        do_load(13'h1005, 1'b1, 8'h3C, 16'h2103, 16'h0000, 16'h3333);
        do_load(13'd7, 1'b1, 8'h01, 16'h0001, 16'h0010, 16'h0100);
        walk("R7 walk3");
        // R8: number bits of key kept after fail
        rreg(3'd1, v); chk("R8 miss key", v, {3'b000, 13'h1005});

        // R5 overwrite
        do_load(13'd300, 1'b1, 8'h77, 16'h0302, 16'h0001, 16'h0000);
        set_key(16'd299); next_chk("R5 overwrite", f);
        chk("R5 found", f, 1);

        // R6 purge
        do_load(13'd300, 1'b0, 8'h00, 16'h0, 16'h0, 16'h0);
        set_key(16'd7); next_chk("R6 purge", f);
        rreg(3'd1, v); chk("R6 next after purge", v, {3'b100, 13'h1005});

        // R3 writes during busy ignored
        e_key = {1'b1, 2'b00, 13'd40};
        wreg(3'd1, e_key);
        wreg(3'd0, {1'b1, 3'd3, 4'h0, 4'h0, 4'h9});
        wreg(3'd1, 16'h0FFF);
        wreg(3'd0, 16'h9000);
        wreg(3'd2, 16'h3333);
        wait_idle(n);
        model_load(13'd40, 1'b1, 8'h09, unpack(e_data[0], e_data[1], e_data[2]));
        e_fid = 8'h09;
        rreg(3'd1, v); chk("R3 key kept", v, e_key);
        rreg(3'd0, v); chk("R3 cmd kept", v, 16'h3009);
        rreg(3'd2, v); chk("R3 data kept", v, e_data[0]);
        walk("R3 no flush");

        // R11 flush
        cmd(3'd1, 8'h00, n);
        chk("R11 busy cycles", n, DEPTH + 1);
        for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
        m_full = 0;
        set_key(16'h0000); next_chk("R11 empty", f);
        chk("R11 nothing found", f, 0);

        // R12 full table
        for (int i = 0; i < DEPTH; i++)
            do_load(13'(100 + 10*i), 1'b1, 8'(i), 16'h1111, 16'h2222, 16'h0000);
        rreg(3'd0, v); chk("R12 not yet full", v[4], 1'b0);
        do_load(13'd95, 1'b1, 8'hEE, 16'h3333, 16'h3333, 16'h3333);
        rreg(3'd0, v); chk("R12 full flag", v[4], 1'b1);
        set_key(16'd0); next_chk("R12 rejected", f);
        rreg(3'd1, v); chk("R12 lowest is 100", v, {3'b100, 13'd100});
        do_load(13'd110, 1'b1, 8'hDD, 16'h0002, 16'h0000, 16'h0000);
        do_load(13'd42, 1'b0, 8'h00, 16'h0, 16'h0, 16'h0);
        rreg(3'd0, v); chk("R12 sticky", v[4], 1'b1);
        set_key(16'd105); next_chk("R12 overwrite when full", f);
        cmd(3'd1, 8'h00, n);
        for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
        m_full = 0;
        rreg(3'd0, v); chk("R11 full cleared", v[4], 1'b0);

        // random mix: R5 R6 R7 R9 R12
        for (int r = 0; r < 80; r++) begin
            int pick = $urandom_range(0, 23);
            logic [12:0] vid = 13'(((pick * 733 + 5) % 8191) + 1);
            logic vld = ($urandom_range(0, 9) < 7);
            do_load(vid, vld, 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            if (r % 10 == 9) walk("R7 random walk");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule